// File: doc/BRIEF.md
# Byte-Wide Staged Control Register Port

This block gives a host a narrow parallel bus into a bank of wide control registers. The host has an 8-bit data path, a 3-bit address, a chip select, a read strobe and a write strobe. The host builds a 32-bit word one byte at a time in a staging register. It then names one of sixteen control registers and requests a commit, and the staged word is copied into that register in the core clock domain. All host-side state is clocked by the rising edge of the write strobe itself, so the host needs no free-running clock. The commit request crosses into the core domain as a toggle through a synchronizer chain.

The address map has three parts. Addresses 0 to 3 load the staging lanes. Address 4 carries the target index and starts the commit. Addresses 5 and 6 set which byte of which register a read returns, and address 7 reads back a status byte. While a commit is in flight, the staging word and the target index are frozen so that the core domain always captures a stable value. The committed bank is also presented in parallel to the core logic.

Top module: `bytewide_cfg_port`

## Requirements
- R1: While rst_n is low, every control register, the staging word and the target index clear to zero and any pending commit is cancelled. After release, every register reads 0 and status bit 0 (busy) reads 0.
- R2: A write strobe with host_sel high to address k (0..3) places the data byte in bits [8k+7:8k] of the staging word and leaves the other lanes unchanged.
- R3: A write to address 4 with host_sel high takes data bits [3:0] as the target index and commits the staging word into that control register. No other control register changes.
- R4: With a two-stage synchronizer, the committed word appears on the target register at the third rising core_clk edge after the commit strobe. It is not visible at the second edge.
- R5: A read of address 7 returns {7'b0, busy}. Busy is 1 from the commit strobe until the core domain captures the word, and 0 otherwise.
- R6: While busy is 1, writes to addresses 0 to 4 are ignored. The staging word, the index and the pending commit are all left as they were.
- R7: The staging word keeps its value after a commit, so a later commit after a partial lane update carries the untouched lanes forward.
- R8: Writing address 5 selects the read lane (data bits [1:0]) and writing address 6 selects the read register (data bits [3:0]). A read with host_sel and host_rd high at any address 0 to 6 then drives byte [8·lane+7:8·lane] of that register onto host_data.
- R9: A write strobe with host_sel low changes no state.
- R10: ctl_bus carries control register r in bits [32r+31:32r].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| core_clk | input | 1 | Core clock for the control register bank |
| host_wr | input | 1 | Write strobe; its rising edge clocks all host-side state |
| host_rd | input | 1 | Read strobe, active high |
| host_sel | input | 1 | Chip select, active high |
| host_addr | input | 3 | Host register address |
| host_data | inout | 8 | Bidirectional data; driven only while host_sel and host_rd are high |
| ctl_bus | output | 512 | All committed control registers, register r at [32r+31:32r] |

## Verification
The assertions assume that host_data and host_addr are stable at each rising write-strobe edge. They also assume that the host never raises host_rd and host_wr together, and that strobe edges are far enough from core_clk edges for the toggle to be sampled cleanly. The stimulus meets these conditions in two ways. First, every host access is launched from the falling core_clk edge, and the bus is changed only while the strobe is low. Second, the bench releases its data drivers before any read starts. Random words, indices and read selections are mixed with directed cases that hit the busy window, an unselected write strobe, and a reset issued while a commit is pending.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
   localparam int unsigned CMD_ADDR       = 4;
   localparam int unsigned RSEL_LANE_ADDR = 5;
   localparam int unsigned RSEL_IDX_ADDR  = 6;
   localparam int unsigned STAT_ADDR      = 7;
   localparam int unsigned MAX_LANES      = 4;

   function automatic int unsigned sel_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/cfgport_host_stage.sv
module cfgport_host_stage
   import cfgport_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned ADDR_W = 3,
   localparam int unsigned LANES  = WORD_W / DATA_W,
   localparam int unsigned LSEL_W = sel_width(LANES)
) (
   input  logic              wr_clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              pend_i,
   output logic [WORD_W-1:0] master_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic              req_o,
   output logic [LSEL_W-1:0] rd_lane_o,
   output logic [IDX_W-1:0]  rd_idx_o
);
   logic              open_wr;
   logic [WORD_W-1:0] master_q;
   logic [DATA_W-1:0] unused_din;

   assign open_wr = sel && !pend_i;
   assign unused_din = din;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      always_ff @(posedge wr_clk or negedge rst_n) begin
         if (!rst_n)
            master_q[k*DATA_W +: DATA_W] <= '0;
         else if (open_wr && addr == ADDR_W'(k))
            master_q[k*DATA_W +: DATA_W] <= din;
      end

      // R2
      lane_load_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
         (open_wr && addr == ADDR_W'(k)) |=> master_o[k*DATA_W +: DATA_W] == $past(din));
   end

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_o <= '0;
         req_o <= 1'b0;
      end else if (open_wr && addr == ADDR_W'(CMD_ADDR)) begin
         idx_o <= din[IDX_W-1:0];
         req_o <= ~req_o;
      end
   end

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_lane_o <= '0;
         rd_idx_o  <= '0;
      end else if (sel) begin
         if (addr == ADDR_W'(RSEL_LANE_ADDR)) rd_lane_o <= din[LSEL_W-1:0];
         if (addr == ADDR_W'(RSEL_IDX_ADDR))  rd_idx_o  <= din[IDX_W-1:0];
      end
   end

   assign master_o = master_q;

   // R6
   frozen_stage_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      pend_i |=> ($stable(master_o) && $stable(idx_o) && $stable(req_o)));
endmodule

// File: rtl/cfgport_commit_sync.sv
module cfgport_commit_sync #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned NREG   = 16,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned SYNC_N = 2
) (
   input  logic                   core_clk,
   input  logic                   rst_n,
   input  logic                   req_i,
   input  logic [WORD_W-1:0]      master_i,
   input  logic [IDX_W-1:0]       idx_i,
   output logic                   ack_o,
   output logic [NREG*WORD_W-1:0] bank_o
);
   logic [SYNC_N:0]    chain;
   logic               cap;
   logic [WORD_W-1:0]  bank [NREG];

   always_ff @(posedge core_clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[SYNC_N-1:0], req_i};
   end

   assign cap = chain[SYNC_N-1] ^ chain[SYNC_N];

   always_ff @(posedge core_clk or negedge rst_n) begin
      if (!rst_n)   ack_o <= 1'b0;
      else if (cap) ack_o <= chain[SYNC_N-1];
   end

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge core_clk or negedge rst_n) begin
         if (!rst_n)
            bank[r] <= '0;
         else if (cap && idx_i == IDX_W'(r))
            bank[r] <= master_i;
      end
      assign bank_o[r*WORD_W +: WORD_W] = bank[r];

      // R3
      untouched_reg_chk: assert property (@(posedge core_clk) disable iff (!rst_n)
         !(cap && idx_i == IDX_W'(r)) |=> $stable(bank_o[r*WORD_W +: WORD_W]));
   end

   // R3
   commit_value_chk: assert property (@(posedge core_clk) disable iff (!rst_n)
      cap |=> bank_o[$past(idx_i)*WORD_W +: WORD_W] == $past(master_i));

   // R5
   pending_seen_chk: assert property (@(posedge core_clk) disable iff (!rst_n)
      (chain[SYNC_N-1] != ack_o) |-> (req_i != ack_o));
endmodule

// File: rtl/cfgport_read_mux.sv
module cfgport_read_mux
   import cfgport_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned NREG   = 16,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned ADDR_W = 3,
   localparam int unsigned LANES  = WORD_W / DATA_W,
   localparam int unsigned LSEL_W = sel_width(LANES)
) (
   input  logic [NREG*WORD_W-1:0] bank_i,
   input  logic [LSEL_W-1:0]      lane_i,
   input  logic [IDX_W-1:0]       idx_i,
   input  logic [ADDR_W-1:0]      addr,
   input  logic                   pend_i,
   output logic [DATA_W-1:0]      byte_o
);
   logic [WORD_W-1:0] word;

   always_comb begin
      word = '0;
      for (int r = 0; r < NREG; r++)
         if (idx_i == IDX_W'(r)) word = bank_i[r*WORD_W +: WORD_W];
   end

   always_comb begin
      if (addr == ADDR_W'(STAT_ADDR)) begin
         byte_o    = '0;
         byte_o[0] = pend_i;
      end else begin
         byte_o = '0;
         for (int k = 0; k < LANES; k++)
            if (lane_i == LSEL_W'(k)) byte_o = word[k*DATA_W +: DATA_W];
      end
   end
endmodule

// File: rtl/bytewide_cfg_port.sv
module bytewide_cfg_port
   import cfgport_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned NREG   = 16,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned SYNC_N = 2,
   localparam int unsigned LANES  = WORD_W / DATA_W,
   localparam int unsigned LSEL_W = sel_width(LANES),
   localparam int unsigned IDX_W  = sel_width(NREG)
) (
   input  logic                   rst_n,
   input  logic                   core_clk,
   input  logic                   host_wr,
   input  logic                   host_rd,
   input  logic                   host_sel,
   input  logic [ADDR_W-1:0]      host_addr,
   inout  wire  [DATA_W-1:0]      host_data,
   output logic [NREG*WORD_W-1:0] ctl_bus
);
   if (WORD_W % DATA_W != 0) begin : g_bad_ratio
      $error("WORD_W must be a multiple of DATA_W");
   end
   if (LANES > MAX_LANES) begin : g_bad_lanes
      $error("at most four byte lanes fit below the command address");
   end
   if (IDX_W > DATA_W) begin : g_bad_idx
      $error("register index must fit in one data byte");
   end
   if (SYNC_N < 2) begin : g_bad_sync
      $error("synchronizer needs at least two stages");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("address map needs three bits");
   end

   logic [WORD_W-1:0] master;
   logic [IDX_W-1:0]  tgt_idx;
   logic              req_tgl, ack_tgl, pend;
   logic [LSEL_W-1:0] rd_lane;
   logic [IDX_W-1:0]  rd_idx;
   logic [DATA_W-1:0] rd_byte;

   assign pend = req_tgl ^ ack_tgl;

   cfgport_host_stage #(
      .DATA_W(DATA_W), .WORD_W(WORD_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
   ) u_stage (
      .wr_clk   (host_wr),
      .rst_n    (rst_n),
      .sel      (host_sel),
      .addr     (host_addr),
      .din      (host_data),
      .pend_i   (pend),
      .master_o (master),
      .idx_o    (tgt_idx),
      .req_o    (req_tgl),
      .rd_lane_o(rd_lane),
      .rd_idx_o (rd_idx)
   );

   cfgport_commit_sync #(
      .WORD_W(WORD_W), .NREG(NREG), .IDX_W(IDX_W), .SYNC_N(SYNC_N)
   ) u_sync (
      .core_clk(core_clk),
      .rst_n   (rst_n),
      .req_i   (req_tgl),
      .master_i(master),
      .idx_i   (tgt_idx),
      .ack_o   (ack_tgl),
      .bank_o  (ctl_bus)
   );

   cfgport_read_mux #(
      .DATA_W(DATA_W), .WORD_W(WORD_W), .NREG(NREG), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
   ) u_rmux (
      .bank_i(ctl_bus),
      .lane_i(rd_lane),
      .idx_i (rd_idx),
      .addr  (host_addr),
      .pend_i(pend),
      .byte_o(rd_byte)
   );

   assign host_data = (host_sel && host_rd) ? rd_byte : {DATA_W{1'bz}};

   // R9
   nosel_hold_chk: assert property (@(posedge host_wr) disable iff (!rst_n)
      !host_sel |=> ($stable(master) && $stable(req_tgl) && $stable(rd_idx)));
endmodule

// File: tb/tb_bytewide_cfg_port.sv
`timescale 1ns/1ps
module tb_bytewide_cfg_port;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         host_wr = 1'b0, host_rd = 1'b0, host_sel = 1'b0;
   logic [2:0]   host_addr = '0;
   logic [7:0]   tb_dout = '0;
   logic         tb_oe = 1'b0;
   wire  [7:0]   host_data;
   logic [511:0] ctl_bus;

   int total = 0, bad = 0;
   logic [31:0] exp_bank [16];
   logic [31:0] exp_master;

   assign host_data = tb_oe ? tb_dout : 8'bz;

   always #10 clk = ~clk;

   bytewide_cfg_port dut (
      .rst_n(rst_n), .core_clk(clk), .host_wr(host_wr), .host_rd(host_rd),
      .host_sel(host_sel), .host_addr(host_addr), .host_data(host_data), .ctl_bus(ctl_bus)
   );

   function automatic logic [7:0] lane_of(input logic [31:0] w, input int k);
      return w[k*8 +: 8];
   endfunction

   function automatic logic [31:0] reg_of(input logic [511:0] b, input int r);
      return b[r*32 +: 32];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic s = 1'b1);
      @(negedge clk);
      host_sel = s; host_addr = a; tb_dout = d; tb_oe = 1'b1;
      #5 host_wr = 1'b1;
      #5 host_wr = 1'b0;
      #1 tb_oe = 1'b0; host_sel = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      host_sel = 1'b1; host_rd = 1'b1; host_addr = a;
      #3 d = host_data;
      host_rd = 1'b0; host_sel = 1'b0;
   endtask

   task automatic stage_word(input logic [31:0] w);
      for (int k = 0; k < 4; k++) wr(3'(k), lane_of(w, k));
      exp_master = w;
   endtask

   task automatic commit_settle(input int idx);
      wr(3'd4, 8'(idx));
      repeat (4) @(posedge clk);
      #2;
      exp_bank[idx] = exp_master;
   endtask

   task automatic read_reg_byte(input int idx, input int lane, output logic [7:0] d);
      wr(3'd5, 8'(lane));
      wr(3'd6, 8'(idx));
      rd(3'(($urandom % 7)), d);
   endtask

   initial begin
      #2_000_000;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] b;
      logic [31:0] w;
      void'($urandom(32'd1234));
      for (int r = 0; r < 16; r++) exp_bank[r] = '0;
      exp_master = '0;
      repeat (3) @(posedge clk);
      #3 rst_n = 1'b1;
      repeat (2) @(posedge clk);

      // R1: reset state
      for (int r = 0; r < 16; r++) check("R1 ctl_bus after reset", reg_of(ctl_bus, r), 32'h0);
      rd(3'd7, b);
      check("R1 status after reset", {24'h0, b}, 32'h0);

      // R2/R10: directed lane placement, then R4 timing
      stage_word(32'hA1B2C3D4);
      wr(3'd4, 8'd9);
      @(posedge clk); #2;
      check("R4 not visible at second edge", reg_of(ctl_bus, 9), 32'h0);
      @(posedge clk); #2;
      check("R4 visible at third edge", reg_of(ctl_bus, 9), 32'hA1B2C3D4);
      exp_bank[9] = exp_master;
      check("R10 slice position", ctl_bus[9*32 +: 32], 32'hA1B2C3D4);
      check("R3 neighbour untouched", reg_of(ctl_bus, 8), 32'h0);

      // R5: busy during pending commit, clear afterwards
      wr(3'd4, 8'd2);
      rd(3'd7, b);
      check("R5 busy while pending", {24'h0, b}, 32'h1);
      repeat (4) @(posedge clk);
      exp_bank[2] = exp_master;
      rd(3'd7, b);
      check("R5 busy cleared", {24'h0, b}, 32'h0);

      // R6: writes while busy are ignored
      stage_word(32'h0BADF00D);
      wr(3'd4, 8'd3);
      wr(3'd0, 8'hEE);
      wr(3'd4, 8'd5);
      repeat (5) @(posedge clk); #2;
      exp_bank[3] = exp_master;
      check("R6 commit target holds staged word", reg_of(ctl_bus, 3), 32'h0BADF00D);
      check("R6 second commit ignored", reg_of(ctl_bus, 5), 32'h0);
      commit_settle(6);
      check("R6 lane write ignored", reg_of(ctl_bus, 6), 32'h0BADF00D);

      // R7: partial lane update carries other lanes
      wr(3'd1, 8'h77);
      exp_master[15:8] = 8'h77;
      commit_settle(7);
      check("R7 partial update", reg_of(ctl_bus, 7), 32'h0BAD770D);

      // R9: unselected strobe changes nothing
      wr(3'd2, 8'h55, 1'b0);
      wr(3'd4, 8'd11, 1'b0);
      repeat (5) @(posedge clk); #2;
      check("R9 no commit without select", reg_of(ctl_bus, 11), 32'h0);
      commit_settle(12);
      check("R9 staging untouched", reg_of(ctl_bus, 12), 32'h0BAD770D);

      // R8: directed readback
      read_reg_byte(9, 3, b);
      check("R8 readback lane3", {24'h0, b}, 32'hA1);
      read_reg_byte(9, 0, b);
      check("R8 readback lane0", {24'h0, b}, 32'hD4);

      // Random stimulus, R2 R3 R8 R10
      for (int it = 0; it < 60; it++) begin
         int idx, lane, ridx;
         w = $urandom;
         idx = int'($urandom % 16);
         stage_word(w);
         commit_settle(idx);
         check("R2 R3 random commit", reg_of(ctl_bus, idx), exp_bank[idx]);
         ridx = int'($urandom % 16);
         lane = int'($urandom % 4);
         read_reg_byte(ridx, lane, b);
         check("R8 random readback", {24'h0, b}, {24'h0, lane_of(exp_bank[ridx], lane)});
      end
      for (int r = 0; r < 16; r++) check("R10 bank image", reg_of(ctl_bus, r), exp_bank[r]);

      // R1: reset during pending commit
      stage_word(32'h12345678);
      wr(3'd4, 8'd1);
      #4 rst_n = 1'b0;
      #30 rst_n = 1'b1;
      repeat (5) @(posedge clk); #2;
      for (int r = 0; r < 16; r++) check("R1 cleared by reset", reg_of(ctl_bus, r), 32'h0);
      rd(3'd7, b);
      check("R1 pending cancelled", {24'h0, b}, 32'h0);
      exp_master = '0;
      commit_settle(4);
      check("R1 staging cleared", reg_of(ctl_bus, 4), 32'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule